// File: doc/BRIEF.md
# Accumulator ALU with status flags

This block is the arithmetic and logic unit of an 8-bit accumulator machine. Each operation takes the accumulator, the B register, a second operand byte and the current status word. It returns a new accumulator, a new B register and a new status word. The status word holds the carry, auxiliary carry, overflow and parity flags. It also carries a user flag, two register-bank select bits and one spare bit, which the block passes through untouched.

The surrounding datapath fetches the operand and owns the architectural registers. It presents one operation per cycle with `op_valid` high. The results appear on registered outputs one clock later, and `res_valid` marks them. The block covers binary add, add with carry and subtract with borrow. It has increment, decrement, the paired B:A multiply and divide, and decimal adjust after BCD addition. It also has rotates with and without carry, nibble swap, the bitwise operations, clear, and an unsigned compare that reports only through carry.

Top module: `acc_alu`

## Requirements
- R1: When `op_valid` is high at a rising edge, the results of that operation appear on `acc_out`, `b_out` and `psw_out` after that edge, and `res_valid` is high for that one cycle. While `op_valid` is low, the outputs hold their values and `res_valid` is low. Opcodes on `op`: 0 add, 1 add with carry, 2 subtract with borrow, 3 increment, 4 decrement, 5 multiply, 6 divide, 7 decimal adjust, 8 rotate left, 9 rotate left through carry, 10 rotate right, 11 rotate right through carry, 12 nibble swap, 13 AND, 14 OR, 15 XOR, 16 complement, 17 clear, 18 compare.
- R2: A synchronous active-high `rst` sets `acc_out`, `b_out` and `psw_out` to 00h and `res_valid` to 0.
- R3: Add computes A+operand, add with carry computes A+operand+CY, and subtract with borrow computes A-operand-CY, each modulo 256. CY is set on a carry out of bit 7 or on a borrow, and cleared otherwise.
- R4: For add, add with carry and subtract with borrow, AC is set on a carry out of bit 3 or a borrow into bit 3, and cleared otherwise.
- R5: For add, add with carry and subtract with borrow, OV is set exactly when the signed result lies outside -128..+127.
- R6: P (status bit 0) always makes the number of ones in `acc_out` plus P even.
- R7: Multiply places A*B with the high byte in B and the low byte in A. It clears CY, and it sets OV exactly when the product exceeds FFh.
- R8: Divide puts the quotient of A/B in A and the remainder in B, and it clears CY and OV. When B is zero it sets OV and clears CY, and A and B are unspecified.
- R9: Decimal adjust adds 06h when the low nibble exceeds 9 or AC is set. It then adds 60h when the high nibble exceeds 9 or a carry is present, either from CY or from the first step. CY is set on a carry out and never cleared, and AC is kept.
- R10: Rotate left moves bit 7 into bit 0, and rotate right moves bit 0 into bit 7, with CY unchanged. The through-carry forms shift the outgoing bit into CY and the old CY into the vacated bit.
- R11: Swap exchanges the nibbles of A. AND, OR and XOR combine A with the operand, complement inverts A, clear writes 00h, and increment and decrement add or subtract 1 modulo 256. None of these change CY, AC or OV.
- R12: Compare leaves A unchanged and sets CY exactly when A is less than the operand taken as unsigned. It changes no other flag.
- R13: The status word is laid out as bit 7 CY, bit 6 AC, bit 5 user flag, bit 4 and bit 3 bank select, bit 2 OV, bit 1 spare, bit 0 P. Bits 5, 4, 3 and 1 are copied from `psw_in`, and flags an operation does not name keep their `psw_in` value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op | input | 5 | Operation code |
| acc_in | input | 8 | Current accumulator |
| b_in | input | 8 | Current B register |
| opnd_in | input | 8 | Second operand byte |
| psw_in | input | 8 | Current status word |
| res_valid | output | 1 | Results on the outputs are fresh |
| acc_out | output | 8 | New accumulator |
| b_out | output | 8 | New B register |
| psw_out | output | 8 | New status word |

## Verification
The arithmetic group is driven with operand pairs chosen so that one pair differs from the next in a single flag. These pairs separate a carry out of bit 7 from a carry out of bit 3, and a signed overflow from an unsigned carry, for add and subtract with and without an incoming carry. Multiply is tried with products on both sides of FFh. Divide is tried with a non-zero and a zero divisor. Decimal adjust is tried with an adjust forced by the nibble value, an adjust forced by the incoming flags, and no adjust at all, which separates the two triggers and shows that an incoming carry is kept. Rotates, compare and the logic group use patterns whose results differ between left and right, with and without carry, and signed against unsigned ordering. Idle cycles with changed inputs and a reset in mid-run check that the outputs hold and clear.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int DW  = 8;
    localparam int NIB = DW / 2;

    // status word bit positions
    localparam int SW_CY  = 7;
    localparam int SW_AC  = 6;
    localparam int SW_OV  = 2;
    localparam int SW_PAR = 0;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADDC = 5'd1,
        OP_SUBB = 5'd2,
        OP_INC  = 5'd3,
        OP_DEC  = 5'd4,
        OP_MUL  = 5'd5,
        OP_DIV  = 5'd6,
        OP_DA   = 5'd7,
        OP_RL   = 5'd8,
        OP_RLC  = 5'd9,
        OP_RR   = 5'd10,
        OP_RRC  = 5'd11,
        OP_SWAP = 5'd12,
        OP_AND  = 5'd13,
        OP_OR   = 5'd14,
        OP_XOR  = 5'd15,
        OP_CPL  = 5'd16,
        OP_CLR  = 5'd17,
        OP_CMP  = 5'd18
    } alu_op_e;

    typedef struct packed {
        logic [DW-1:0] acc;
        logic [DW-1:0] b;
        logic          cy;
        logic          ac;
        logic          ov;
    } alu_res_t;

    function automatic logic even_fill(input logic [DW-1:0] v);
        return ^v;
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import acc_alu_pkg::*;
#(
    parameter int W = DW,
    parameter int H = W / 2
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         cy_o,
    output logic         ac_o,
    output logic         ov_o
);
    logic [W:0] full;
    logic [H:0] low;

    always_comb begin
        if (sub_i) begin
            full = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
            low  = {1'b0, a_i[H-1:0]} - {1'b0, b_i[H-1:0]} - {{H{1'b0}}, cin_i};
            ov_o = (a_i[W-1] ^ b_i[W-1]) & (full[W-1] ^ a_i[W-1]);
        end else begin
            full = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
            low  = {1'b0, a_i[H-1:0]} + {1'b0, b_i[H-1:0]} + {{H{1'b0}}, cin_i};
            ov_o = ~(a_i[W-1] ^ b_i[W-1]) & (full[W-1] ^ a_i[W-1]);
        end
        sum_o = full[W-1:0];
        cy_o  = full[W];
        ac_o  = low[H];
    end
endmodule

// File: rtl/alu_muldiv.sv
module alu_muldiv
    import acc_alu_pkg::*;
#(
    parameter int W = DW
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] prod_lo_o,
    output logic [W-1:0] prod_hi_o,
    output logic         prod_big_o,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o,
    output logic         div_zero_o
);
    localparam int PW = 2 * W;

    logic [PW-1:0] prod;

    assign prod       = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
    assign prod_lo_o  = prod[W-1:0];
    assign prod_hi_o  = prod[PW-1:W];
    assign prod_big_o = |prod[PW-1:W];
    assign div_zero_o = (b_i == '0);

    // restoring division, one trial subtract per dividend bit, MSB first
    always_comb begin
        logic [W-1:0] part;
        logic [W:0]   trial;
        part  = '0;
        quo_o = '0;
        for (int k = W - 1; k >= 0; k--) begin
            trial = {part, a_i[k]};
            if (trial >= {1'b0, b_i}) begin
                quo_o[k] = 1'b1;
                trial    = trial - {1'b0, b_i};
            end
            part = trial[W-1:0];
        end
        rem_o = part;
    end

    always_comb begin
        logic [PW-1:0] back;
        back = {{W{1'b0}}, quo_o} * {{W{1'b0}}, b_i} + {{W{1'b0}}, rem_o};
        if (b_i != '0) begin
            AST_DIV_IDENTITY: assert (back == {{W{1'b0}}, a_i}); // R8
            AST_DIV_REM_BELOW: assert (rem_o < b_i); // R8
        end
    end
endmodule

// File: rtl/alu_decadj.sv
module alu_decadj
    import acc_alu_pkg::*;
#(
    parameter int W = DW,
    parameter int H = W / 2
) (
    input  logic [W-1:0] a_i,
    input  logic         cy_i,
    input  logic         ac_i,
    output logic [W-1:0] res_o,
    output logic         cy_o
);
    localparam logic [H-1:0] NINE = H'(9);
    localparam logic [H-1:0] SIX  = H'(6);

    logic [W:0] step1;
    logic [W:0] step2;
    logic       lo_fix;
    logic       hi_fix;
    logic       c1;

    always_comb begin
        lo_fix = (a_i[H-1:0] > NINE) | ac_i;
        step1  = {1'b0, a_i} + (lo_fix ? {{(W+1-H){1'b0}}, SIX} : '0);
        c1     = step1[W] | cy_i;
        hi_fix = (step1[W-1:H] > NINE) | c1;
        step2  = {1'b0, step1[W-1:0]} + (hi_fix ? {1'b0, SIX, {H{1'b0}}} : '0);
        res_o  = step2[W-1:0];
        cy_o   = c1 | step2[W];
    end
endmodule

// File: rtl/alu_shiftlog.sv
module alu_shiftlog
    import acc_alu_pkg::*;
#(
    parameter int W = DW,
    parameter int H = W / 2
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] opnd_i,
    input  logic         cy_i,
    output logic [W-1:0] res_o,
    output logic         cy_o,
    output logic         cy_wr_o
);
    always_comb begin
        res_o   = a_i;
        cy_o    = cy_i;
        cy_wr_o = 1'b0;
        unique case (op_i)
            OP_INC:  res_o = a_i + W'(1);
            OP_DEC:  res_o = a_i - W'(1);
            OP_RL:   res_o = {a_i[W-2:0], a_i[W-1]};
            OP_RR:   res_o = {a_i[0], a_i[W-1:1]};
            OP_RLC: begin
                res_o   = {a_i[W-2:0], cy_i};
                cy_o    = a_i[W-1];
                cy_wr_o = 1'b1;
            end
            OP_RRC: begin
                res_o   = {cy_i, a_i[W-1:1]};
                cy_o    = a_i[0];
                cy_wr_o = 1'b1;
            end
            OP_SWAP: res_o = {a_i[H-1:0], a_i[W-1:H]};
            OP_AND:  res_o = a_i & opnd_i;
            OP_OR:   res_o = a_i | opnd_i;
            OP_XOR:  res_o = a_i ^ opnd_i;
            OP_CPL:  res_o = ~a_i;
            OP_CLR:  res_o = '0;
            OP_CMP: begin
                cy_o    = (a_i < opnd_i);
                cy_wr_o = 1'b1;
            end
            default: res_o = a_i;
        endcase
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         op_valid,
    input  logic [4:0]   op,
    input  logic [W-1:0] acc_in,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] opnd_in,
    input  logic [7:0]   psw_in,
    output logic         res_valid,
    output logic [W-1:0] acc_out,
    output logic [W-1:0] b_out,
    output logic [7:0]   psw_out
);
    alu_op_e  op_e;
    alu_res_t nxt;
    logic [7:0] nxt_psw;

    logic [W-1:0] as_sum;
    logic         as_cy, as_ac, as_ov;
    logic [W-1:0] md_lo, md_hi, md_quo, md_rem;
    logic         md_big, md_zero;
    logic [W-1:0] da_res;
    logic         da_cy;
    logic [W-1:0] sl_res;
    logic         sl_cy, sl_cy_wr;

    assign op_e = alu_op_e'(op);

    alu_addsub #(.W(W)) u_addsub (
        .a_i   (acc_in),
        .b_i   (opnd_in),
        .cin_i ((op_e != OP_ADD) & psw_in[SW_CY]),
        .sub_i (op_e == OP_SUBB),
        .sum_o (as_sum),
        .cy_o  (as_cy),
        .ac_o  (as_ac),
        .ov_o  (as_ov)
    );

    alu_muldiv #(.W(W)) u_muldiv (
        .a_i        (acc_in),
        .b_i        (b_in),
        .prod_lo_o  (md_lo),
        .prod_hi_o  (md_hi),
        .prod_big_o (md_big),
        .quo_o      (md_quo),
        .rem_o      (md_rem),
        .div_zero_o (md_zero)
    );

    alu_decadj #(.W(W)) u_decadj (
        .a_i   (acc_in),
        .cy_i  (psw_in[SW_CY]),
        .ac_i  (psw_in[SW_AC]),
        .res_o (da_res),
        .cy_o  (da_cy)
    );

    alu_shiftlog #(.W(W)) u_shiftlog (
        .op_i    (op_e),
        .a_i     (acc_in),
        .opnd_i  (opnd_in),
        .cy_i    (psw_in[SW_CY]),
        .res_o   (sl_res),
        .cy_o    (sl_cy),
        .cy_wr_o (sl_cy_wr)
    );

    always_comb begin
        nxt.acc = acc_in;
        nxt.b   = b_in;
        nxt.cy  = psw_in[SW_CY];
        nxt.ac  = psw_in[SW_AC];
        nxt.ov  = psw_in[SW_OV];
        case (op_e)
            OP_ADD, OP_ADDC, OP_SUBB: begin
                nxt.acc = as_sum;
                nxt.cy  = as_cy;
                nxt.ac  = as_ac;
                nxt.ov  = as_ov;
            end
            OP_MUL: begin
                nxt.acc = md_lo;
                nxt.b   = md_hi;
                nxt.cy  = 1'b0;
                nxt.ov  = md_big;
            end
            OP_DIV: begin
                nxt.acc = md_quo;
                nxt.b   = md_rem;
                nxt.cy  = 1'b0;
                nxt.ov  = md_zero;
            end
            OP_DA: begin
                nxt.acc = da_res;
                nxt.cy  = da_cy;
            end
            default: begin
                nxt.acc = sl_res;
                if (sl_cy_wr) nxt.cy = sl_cy;
            end
        endcase
        nxt_psw = {nxt.cy, nxt.ac, psw_in[5:3], nxt.ov, psw_in[1],
                   even_fill(nxt.acc)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            acc_out   <= '0;
            b_out     <= '0;
            psw_out   <= '0;
        end else begin
            res_valid <= op_valid;
            if (op_valid) begin
                acc_out <= nxt.acc;
                b_out   <= nxt.b;
                psw_out <= nxt_psw;
            end
        end
    end

    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_valid); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> (!res_valid && $stable(acc_out) && $stable(b_out) && $stable(psw_out))); // R1
    AST_PARITY_EVEN: assert property (@(posedge clk) disable iff (rst)
        (^{acc_out, psw_out[SW_PAR]}) == 1'b0); // R6
    AST_MODE_BITS_COPY: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> (psw_out[5:3] == $past(psw_in[5:3]) && psw_out[1] == $past(psw_in[1]))); // R13
    AST_MULDIV_CY_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op == 5'd5 || op == 5'd6)) |=> !psw_out[SW_CY]); // R7
    AST_DA_KEEPS_CY: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op == 5'd7 && psw_in[SW_CY]) |=> psw_out[SW_CY]); // R9
    AST_CMP_ACC_KEPT: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op == 5'd18) |=> (acc_out == $past(acc_in))); // R12
endmodule

// File: tb/acc_alu_bench.sv
module acc_alu_bench;

    typedef struct packed {
        logic [4:0] op;
        logic [7:0] a;
        logic [7:0] b;
        logic [7:0] o;
        logic [7:0] psw;
        logic [7:0] ea;
        logic [7:0] eb;
        logic [7:0] ep;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VT [NV] = '{
        '{5'd0,  8'h35, 8'h11, 8'h53, 8'h00, 8'h88, 8'h11, 8'h04, 4'd5},  // R5 add overflow
        '{5'd0,  8'hFF, 8'h11, 8'h01, 8'h00, 8'h00, 8'h11, 8'hC0, 4'd3},  // R3 R4 carry out
        '{5'd1,  8'h7F, 8'h11, 8'h00, 8'h80, 8'h80, 8'h11, 8'h45, 4'd4},  // R4 carry-in ripple
        '{5'd2,  8'h10, 8'h11, 8'h01, 8'h00, 8'h0F, 8'h11, 8'h40, 4'd4},  // R4 nibble borrow
        '{5'd2,  8'h00, 8'h11, 8'h00, 8'h80, 8'hFF, 8'h11, 8'hC0, 4'd3},  // R3 borrow
        '{5'd2,  8'h80, 8'h11, 8'h01, 8'h18, 8'h7F, 8'h11, 8'h5D, 4'd5},  // R5 R13 sub overflow
        '{5'd3,  8'hFF, 8'h11, 8'h00, 8'h84, 8'h00, 8'h11, 8'h84, 4'd11}, // R11 inc keeps flags
        '{5'd4,  8'h00, 8'h11, 8'h00, 8'h00, 8'hFF, 8'h11, 8'h00, 4'd11}, // R11 dec wrap
        '{5'd5,  8'h50, 8'hA0, 8'h00, 8'h80, 8'h00, 8'h32, 8'h04, 4'd7},  // R7 big product
        '{5'd5,  8'h0F, 8'h03, 8'h00, 8'h84, 8'h2D, 8'h00, 8'h00, 4'd7},  // R7 small product
        '{5'd6,  8'hFB, 8'h12, 8'h00, 8'h80, 8'h0D, 8'h11, 8'h01, 4'd8},  // R8 divide
        '{5'd7,  8'h9A, 8'h11, 8'h00, 8'h00, 8'h00, 8'h11, 8'h80, 4'd9},  // R9 nibble-driven
        '{5'd7,  8'h35, 8'h11, 8'h00, 8'hC0, 8'h9B, 8'h11, 8'hC1, 4'd9},  // R9 flag-driven
        '{5'd7,  8'h12, 8'h11, 8'h00, 8'h00, 8'h12, 8'h11, 8'h00, 4'd9},  // R9 no adjust
        '{5'd8,  8'h81, 8'h11, 8'h00, 8'h80, 8'h03, 8'h11, 8'h80, 4'd10}, // R10 rl
        '{5'd9,  8'h81, 8'h11, 8'h00, 8'h00, 8'h02, 8'h11, 8'h81, 4'd10}, // R10 rlc
        '{5'd10, 8'h01, 8'h11, 8'h00, 8'h00, 8'h80, 8'h11, 8'h01, 4'd10}, // R10 rr
        '{5'd11, 8'h01, 8'h11, 8'h00, 8'h80, 8'h80, 8'h11, 8'h81, 4'd10}, // R10 rrc
        '{5'd12, 8'h3C, 8'h11, 8'h00, 8'h18, 8'hC3, 8'h11, 8'h18, 4'd11}, // R11 swap
        '{5'd13, 8'h35, 8'h11, 8'h53, 8'h00, 8'h11, 8'h11, 8'h00, 4'd11}, // R11 and
        '{5'd14, 8'h35, 8'h11, 8'h53, 8'h00, 8'h77, 8'h11, 8'h00, 4'd11}, // R11 or
        '{5'd15, 8'h35, 8'h11, 8'h53, 8'h00, 8'h66, 8'h11, 8'h00, 4'd11}, // R11 xor
        '{5'd16, 8'h35, 8'h11, 8'h00, 8'h00, 8'hCA, 8'h11, 8'h00, 4'd11}, // R11 cpl
        '{5'd17, 8'h35, 8'h11, 8'h00, 8'h80, 8'h00, 8'h11, 8'h80, 4'd11}, // R11 clr
        '{5'd18, 8'h10, 8'h11, 8'h20, 8'h00, 8'h10, 8'h11, 8'h81, 4'd12}, // R12 less
        '{5'd18, 8'h20, 8'h11, 8'h20, 8'h80, 8'h20, 8'h11, 8'h01, 4'd12}, // R12 equal
        '{5'd18, 8'hF0, 8'h11, 8'h0F, 8'h00, 8'hF0, 8'h11, 8'h00, 4'd12}, // R12 unsigned
        '{5'd0,  8'h07, 8'h11, 8'h01, 8'h3A, 8'h08, 8'h11, 8'h3B, 4'd6}   // R6 R13 odd parity
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [4:0] op = '0;
    logic [7:0] acc_in = '0, b_in = '0, opnd_in = '0, psw_in = '0;
    logic       res_valid;
    logic [7:0] acc_out, b_out, psw_out;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    acc_alu u_acc_alu (
        .clk       (clk),
        .rst       (rst),
        .op_valid  (op_valid),
        .op        (op),
        .acc_in    (acc_in),
        .b_in      (b_in),
        .opnd_in   (opnd_in),
        .psw_in    (psw_in),
        .res_valid (res_valid),
        .acc_out   (acc_out),
        .b_out     (b_out),
        .psw_out   (psw_out)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [4:0] c, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] o, input logic [7:0] p);
        @(negedge clk);
        op = c; acc_in = a; b_in = b; opnd_in = o; psw_in = p;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog: actual not done expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2 reset state
        chk("R2 acc", acc_out, 8'h00);
        chk("R2 b", b_out, 8'h00);
        chk("R2 psw", psw_out, 8'h00);
        chk("R2 valid", {7'd0, res_valid}, 8'h00);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VT[i].op, VT[i].a, VT[i].b, VT[i].o, VT[i].psw);
            chk($sformatf("R%0d vec%0d acc", VT[i].rq, i), acc_out, VT[i].ea);
            chk($sformatf("R%0d vec%0d b", VT[i].rq, i), b_out, VT[i].eb);
            chk($sformatf("R%0d vec%0d psw", VT[i].rq, i), psw_out, VT[i].ep);
            chk("R6 parity", {7'd0, ^{acc_out, psw_out[0]}}, 8'h00);
        end

        // R8 divide by zero: CY clear, OV set
        apply(5'd6, 8'h42, 8'h00, 8'h00, 8'h80);
        chk("R8 div0 cy/ov", psw_out & 8'h84, 8'h04);

        // R1 valid pulse and hold while idle
        apply(5'd0, 8'h01, 8'h22, 8'h02, 8'h00);
        chk("R1 valid pulse", {7'd0, res_valid}, 8'h01);
        chk("R1 acc", acc_out, 8'h03);
        @(negedge clk);
        op = 5'd17; acc_in = 8'hAA; b_in = 8'h55; psw_in = 8'hFF;
        @(negedge clk);
        chk("R1 valid drop", {7'd0, res_valid}, 8'h00);
        chk("R1 hold acc", acc_out, 8'h03);
        chk("R1 hold b", b_out, 8'h22);
        chk("R1 hold psw", psw_out, 8'h00);

        // R2 reset in mid-run
        apply(5'd16, 8'h00, 8'h77, 8'h00, 8'hF8);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R2 mid acc", acc_out, 8'h00);
        chk("R2 mid b", b_out, 8'h00);
        chk("R2 mid psw", psw_out, 8'h00);
        rst = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule